// File: doc/BRIEF.md
# Supply and Power-Up Write Guard

This block decides, cycle by cycle, whether an external write or store request may reach the storage array. It watches a digital low-supply indication, the active-low chip-select and write strobes, a store-request line, and single-cycle pulses that mark three events: power-up, the end of a recall, and the end of a store. Its two outputs are a write-allow and a store-allow qualifier. These outputs feed the array control logic.

While the supply is low, both writes and stores are refused. A write strobe pair that is already held active when one of the three events happens is not trusted. The guard arms a hold-off flag on each event and keeps writes refused until it sees a fresh high-to-low transition on either strobe. A slow or bouncing supply therefore cannot turn a stale bus state into a write. The guard does not sense the supply voltage. It takes only a digital flag.

Top module: `write_guard`

## Requirements
- R1: `writeAllow` can be 1 only in a cycle where `ceN` and `weN` are both 0.
- R2: While `lowVolt` is 1, `writeAllow` is 0.
- R3: `storeAllow` equals `storeReq` AND NOT `lowVolt`. It does not depend on the hold-off flag or on the strobes.
- R4: After reset, or in the cycle after a `powerUpEvt` pulse, a write held active is refused. It stays refused until a falling edge on `ceN` or `weN`. The write is allowed in the cycle the edge is seen, which is a cycle where the previous-cycle value of the strobe was 1 and the current value is 0. Reset treats both strobes as previously 0, so strobes held low through reset make no edge.
- R5: The same hold-off applies after a `recallDoneEvt` pulse.
- R6: The same hold-off applies after a `storeDoneEvt` pulse.
- R7: In a cycle with any event pulse, `writeAllow` is 0. If a falling edge lands in that same cycle, the event wins, and the hold-off stays armed.
- R8: A falling edge on either strobe alone clears the hold-off. This works for a `ceN` edge while `weN` stays low, and for a `weN` edge while `ceN` stays low.
- R9: With the hold-off clear and no event, a write held active for many cycles stays allowed, unless `lowVolt` is 1.
- R10: A falling edge seen while `lowVolt` is 1 still clears the hold-off. When `lowVolt` returns to 0 with the write still held, the write is allowed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset; arms the hold-off |
| lowVolt | input | 1 | Supply-low indication, 1 = low |
| ceN | input | 1 | Chip-select strobe, active low |
| weN | input | 1 | Write strobe, active low |
| storeReq | input | 1 | Externally requested store |
| powerUpEvt | input | 1 | One-cycle pulse at power-up |
| recallDoneEvt | input | 1 | One-cycle pulse when a recall completes |
| storeDoneEvt | input | 1 | One-cycle pulse when a store completes |
| writeAllow | output | 1 | Write may proceed this cycle |
| storeAllow | output | 1 | Store may proceed this cycle |

## Verification
The two functions that can fall in the same cycle are the arming of the hold-off by an event pulse and its release by a strobe falling edge. The bench provokes this case directly by driving `ceN` low in the same cycle as a store-done or recall-done pulse. It then holds the write, and expects `writeAllow` to stay 0 in that cycle and in the following ones, until a later edge. Random phases raise events and toggle strobes often enough to hit the same overlap many more times. A cycle-level reference model in the bench judges every cycle against the event-wins rule.

// File: rtl/guard_pkg.sv
package guard_pkg;
  // control -> datapath strobes
  typedef struct packed {
    logic rearmHold;  // hold-off armed, waiting for a fresh strobe edge
    logic eventNow;   // an arming event is present this cycle
  } guardStrobes_t;

  localparam int NUM_STROBES = 2;
  localparam int NUM_EVENTS  = 3;
endpackage

// File: rtl/wg_control.sv
module wg_control
  import guard_pkg::*;
#(
  parameter int NUM_EVT = NUM_EVENTS
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_EVT-1:0] evtVec,
  input  logic               fallSeen,
  output guardStrobes_t      strobes
);
  logic rearmQ;
  logic anyEvt;

  assign anyEvt = |evtVec;

  // event has priority over a same-cycle edge
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)         rearmQ <= 1'b1;
    else if (anyEvt)   rearmQ <= 1'b1;
    else if (fallSeen) rearmQ <= 1'b0;
  end

  always_comb begin
    strobes.rearmHold = rearmQ;
    strobes.eventNow  = anyEvt;
  end
endmodule

// File: rtl/wg_datapath.sv
module wg_datapath
  import guard_pkg::*;
#(
  parameter int NUM_STB = NUM_STROBES
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_STB-1:0] strobeN,
  input  logic               lowVolt,
  input  logic               storeReq,
  input  guardStrobes_t      strobes,
  output logic               fallSeen,
  output logic               writeAllow,
  output logic               storeAllow
);
  logic [NUM_STB-1:0] prevQ;
  logic [NUM_STB-1:0] fallVec;
  logic               wrActive;

  // per-strobe edge detector; reset as "previously low" so a held strobe is no edge
  for (genvar i = 0; i < NUM_STB; i++) begin : g_edge
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) prevQ[i] <= 1'b0;
      else       prevQ[i] <= strobeN[i];
    end
    assign fallVec[i] = prevQ[i] & ~strobeN[i];
  end

  assign fallSeen = |fallVec;
  assign wrActive = ~|strobeN;

  always_comb begin
    writeAllow = wrActive && !lowVolt && !strobes.eventNow
                 && (!strobes.rearmHold || fallSeen);
    storeAllow = storeReq && !lowVolt;
  end
endmodule

// File: rtl/write_guard.sv
module write_guard
  import guard_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic lowVolt,
  input  logic ceN,
  input  logic weN,
  input  logic storeReq,
  input  logic powerUpEvt,
  input  logic recallDoneEvt,
  input  logic storeDoneEvt,
  output logic writeAllow,
  output logic storeAllow
);
  guardStrobes_t strobes;
  logic          fallSeen;

  wg_control #(.NUM_EVT(NUM_EVENTS)) u_ctl (
    .clk      (clk),
    .rstN     (rstN),
    .evtVec   ({storeDoneEvt, recallDoneEvt, powerUpEvt}),
    .fallSeen (fallSeen),
    .strobes  (strobes)
  );

  wg_datapath #(.NUM_STB(NUM_STROBES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobeN    ({weN, ceN}),
    .lowVolt    (lowVolt),
    .storeReq   (storeReq),
    .strobes    (strobes),
    .fallSeen   (fallSeen),
    .writeAllow (writeAllow),
    .storeAllow (storeAllow)
  );
endmodule

// File: rtl/write_guard_chk.sv
module write_guard_chk (
  input logic clk,
  input logic rstN,
  input logic lowVolt,
  input logic ceN,
  input logic weN,
  input logic storeReq,
  input logic powerUpEvt,
  input logic recallDoneEvt,
  input logic storeDoneEvt,
  input logic writeAllow,
  input logic storeAllow
);
  logic anyEvt;
  assign anyEvt = powerUpEvt | recallDoneEvt | storeDoneEvt;

  AST_WR_NEEDS_STROBES: assert property (@(posedge clk) disable iff (!rstN)
    writeAllow |-> (!ceN && !weN)); // R1

  AST_LOWV_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    lowVolt |-> !writeAllow); // R2

  AST_STORE_GATE: assert property (@(posedge clk) disable iff (!rstN)
    storeAllow == (storeReq && !lowVolt)); // R3

  AST_EVENT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    anyEvt |-> !writeAllow); // R7

  AST_HELD_AFTER_EVENT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(anyEvt) && $past(!ceN) && $past(!weN) && !ceN && !weN) |-> !writeAllow); // R4
endmodule

bind write_guard write_guard_chk u_chk (.*);

// File: tb/write_guard_bench.sv
`timescale 1ns/1ps
module write_guard_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowVolt = 1'b0, ceN = 1'b0, weN = 1'b0, storeReq = 1'b0;
  logic powerUpEvt = 1'b0, recallDoneEvt = 1'b0, storeDoneEvt = 1'b0;
  logic writeAllow, storeAllow;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // reference model state
  bit mRearm = 1'b1;
  bit mPrevCe = 1'b0;
  bit mPrevWe = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  write_guard u_write_guard (.*);

  function automatic bit expWrite(bit ce, bit we, bit lv, bit ev, bit rearm, bit pce, bit pwe);
    bit fall = (pce && !ce) || (pwe && !we);
    return !ce && !we && !lv && !ev && (!rearm || fall);
  endfunction

  function automatic bit expStore(bit sr, bit lv);
    return sr && !lv;
  endfunction

  task automatic check(input bit act, input bit exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // drive one cycle at negedge, check mid-cycle, then advance the model
  task automatic step(input bit ce, input bit we, input bit lv, input bit sr,
                      input bit pu, input bit rc, input bit sd, input string tag);
    bit ev, fall;
    @(negedge clk);
    ceN = ce; weN = we; lowVolt = lv; storeReq = sr;
    powerUpEvt = pu; recallDoneEvt = rc; storeDoneEvt = sd;
    #2;
    ev = pu | rc | sd;
    fall = (mPrevCe && !ce) || (mPrevWe && !we);
    check(writeAllow, expWrite(ce, we, lv, ev, mRearm, mPrevCe, mPrevWe), {tag, " writeAllow"});
    check(storeAllow, expStore(sr, lv), {tag, " storeAllow"});
    if (ev) mRearm = 1'b1;
    else if (fall) mRearm = 1'b0;
    mPrevCe = ce; mPrevWe = we;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    int seed;
    seed = 32'h5eed_1234;
    void'($urandom(seed));
    // reset with write strobes held low
    repeat (3) @(posedge clk);
    #2;
    check(writeAllow, 1'b0, "R4 reset state writeAllow");
    check(storeAllow, 1'b0, "R3 reset state storeAllow");
    @(negedge clk) rstN = 1'b1;

    // R4: held write after reset is refused until an edge
    step(0,0,0,0, 0,0,0, "R4 held after reset");
    step(0,0,0,0, 0,0,0, "R4 still held");
    step(1,0,0,0, 0,0,0, "R1 ce high no write");
    step(0,0,0,0, 0,0,0, "R8 ce edge allows");
    step(0,0,0,0, 0,0,0, "R9 held write stays");
    step(0,0,0,0, 0,0,0, "R9 held write stays 2");
    // R4 power-up pulse
    step(0,0,0,0, 1,0,0, "R4 powerup cycle");
    step(0,0,0,0, 0,0,0, "R4 after powerup");
    // R5 recall done, then we edge
    step(1,1,0,0, 0,0,0, "R5 idle");
    step(0,0,0,0, 0,0,0, "R5 fresh write");
    step(0,0,0,0, 0,1,0, "R5 recall cycle");
    step(0,0,0,0, 0,0,0, "R5 after recall");
    step(0,1,0,0, 0,0,0, "R1 we high");
    step(0,0,0,0, 0,0,0, "R8 we edge allows");
    // R6 store done
    step(0,0,0,1, 0,0,1, "R6 store cycle");
    step(0,0,0,1, 0,0,0, "R6 after store");
    step(0,0,0,1, 0,0,0, "R3 store ignores hold-off");
    // R7 edge and event same cycle
    step(1,0,0,0, 0,0,0, "R7 setup");
    step(0,0,0,0, 0,0,1, "R7 edge with event");
    step(0,0,0,0, 0,0,0, "R7 still held off");
    step(1,0,0,0, 0,0,0, "R7 release");
    step(0,0,0,0, 0,0,0, "R7 new edge allows");
    // R2 / R3 low supply
    step(0,0,1,1, 0,0,0, "R2 low supply blocks");
    step(0,0,0,1, 0,0,0, "R2 supply back");
    // R10 edge during low supply
    step(0,0,1,0, 0,1,0, "R10 event in lowv");
    step(1,0,1,0, 0,0,0, "R10 ce high");
    step(0,0,1,0, 0,0,0, "R10 edge in lowv");
    step(0,0,0,0, 0,0,0, "R10 supply back allows");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      bit ce, we, lv, sr, pu, rc, sd;
      ce = ($urandom % 3) == 0;
      we = ($urandom % 3) == 0;
      lv = ($urandom % 8) == 0;
      sr = $urandom % 2;
      pu = ($urandom % 20) == 0;
      rc = ($urandom % 12) == 0;
      sd = ($urandom % 12) == 0;
      step(ce, we, lv, sr, pu, rc, sd, "R1-rand R7 rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule